// File: doc/BRIEF.md
# DMA Channel Register Port Interface

This block is the processor-side register file of a four-channel DMA controller. A host reaches it over an 8-bit I/O bus carrying a port number and read and write strobes. Each channel keeps a 16-bit base address, a 16-bit base count and an 8-bit page value, all written by the host. Each channel also holds a current address and a current count, which the transfer engine loads through a side port. All 16-bit quantities pass through 8-bit ports. A single byte-pointer bit, shared by every channel, chooses which half of the register a given access touches.

The transfer engine reads the base and page values straight from the block's outputs. It watches a per-channel changed flag that rises whenever the host rewrites one of that channel's programmed values, and it clears the flag with an acknowledge pulse. Count reads return the current count less one, so a fully drained channel reads back as all ones.

Top module: `dma_chan_regfile`

## Requirements
- R1: Ports 0, 2, 4 and 6 select the address register of channels 0, 1, 2 and 3. Ports 1, 3, 5 and 7 select the count register of those same channels.
- R2: Each read or write of ports 0 to 7 inverts the shared byte pointer once. Page-port and unmapped accesses leave the pointer unchanged.
- R3: A pointer value of 1 selects the low byte (bits 7:0) and a value of 0 selects the high byte (bits 15:8). After reset the pointer is 1.
- R4: A write to an address or count port replaces only the selected byte of the base register. The other byte is kept.
- R5: A read of an address port returns the selected byte of that channel's current address on io_rdata in the same cycle as io_rd.
- R6: A read of a count port returns the selected byte of (current count − 1) modulo 2^16. A count of 0 therefore reads as 0xFF in both bytes.
- R7: Writes to page ports 0x81, 0x82, 0x83 and 0x87 load the page register of channels 2, 3, 1 and 0 respectively. A read of a page port returns that page value.
- R8: A write to a channel's base address, base count or page register sets bit n of chg_flag for that channel n on the next clock edge.
- R9: A high bit n of chg_ack clears chg_flag bit n. If a write to channel n happens in the same cycle, the flag stays set.
- R10: A read of any other port returns 0xFF. A write to any other port changes no base, page, flag or pointer state.
- R11: A cycle with ld_en high loads ld_addr and ld_cnt into the current address and current count of channel ld_chan.
- R12: After reset, every base, current and page register is zero and chg_flag is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| io_port | input | 8 | Port number of the host access |
| io_rd | input | 1 | Host read strobe |
| io_wr | input | 1 | Host write strobe |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Read data, valid while io_rd is high; 0xFF otherwise |
| ld_en | input | 1 | Side-port load strobe from the transfer engine |
| ld_chan | input | 2 | Channel loaded by the side port |
| ld_addr | input | 16 | Current address value to load |
| ld_cnt | input | 16 | Current count value to load |
| chg_ack | input | 4 | Per-channel acknowledge that clears the changed flag |
| chg_flag | output | 4 | Per-channel changed flag |
| base_addr_o | output | 64 | Base addresses; channel n in bits 16n+15:16n |
| base_cnt_o | output | 64 | Base counts; channel n in bits 16n+15:16n |
| page_o | output | 32 | Page registers; channel n in bits 8n+7:8n |

## Verification
The bench rewrites one byte of a register that is already programmed. A design that ORs bytes in, or clears the other half, shows a corrupted base value. The bench also sends page and unmapped accesses between 16-bit halves; a design that toggles the pointer on those returns the wrong byte on the next read. The bench reads a count of zero and a count of one, which catches a count read without the minus-one or with the wrong wrap. It writes each page port separately to catch a straight rather than a scrambled channel map. Finally, it raises an acknowledge in the same cycle as a write, so a design that lets the clear win loses the change indication.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;

  localparam int REG_W  = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_ADDR = 2'd1,
    ACC_CNT  = 2'd2,
    ACC_PAGE = 2'd3
  } acc_kind_e;

  // Page ports sit at 0x81..0x87; only four of them are wired, in a scrambled order.
  function automatic logic [2:0] page_port_map(input logic [2:0] low3);
    logic [2:0] res;
    case (low3)
      3'd1:    res = {1'b1, 2'd2};
      3'd2:    res = {1'b1, 2'd3};
      3'd3:    res = {1'b1, 2'd1};
      3'd7:    res = {1'b1, 2'd0};
      default: res = {1'b0, 2'd0};
    endcase
    return res; // bit 2 = port is wired, bits 1:0 = channel
  endfunction

endpackage

// File: rtl/dmareg_decode.sv
module dmareg_decode
  import dmareg_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [7:0]     port,
  output acc_kind_e      kind,
  output logic [CHW-1:0] chan
);

  localparam logic [7:0] REG_LIMIT = 8'(2 * NCH);

  logic [2:0] pg;

  always_comb begin
    pg   = page_port_map(port[2:0]);
    kind = ACC_NONE;
    chan = '0;
    if (port < REG_LIMIT) begin
      kind = port[0] ? ACC_CNT : ACC_ADDR;
      chan = port[CHW:1];
    end else if ((port[7:3] == 5'b10000) && pg[2]) begin
      kind = ACC_PAGE;
      chan = CHW'(pg[1:0]);
    end
  end

endmodule

// File: rtl/dmareg_chan.sv
module dmareg_chan
  import dmareg_pkg::*;
#(
  parameter int PW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_addr,
  input  logic              wr_cnt,
  input  logic              wr_page,
  input  logic              lo_sel,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              ld_en,
  input  logic [REG_W-1:0]  ld_addr,
  input  logic [REG_W-1:0]  ld_cnt,
  input  logic              ack,
  output logic [REG_W-1:0]  base_addr,
  output logic [REG_W-1:0]  base_cnt,
  output logic [PW-1:0]     page,
  output logic [REG_W-1:0]  cur_addr,
  output logic [REG_W-1:0]  cur_cnt,
  output logic              changed
);

  logic [REG_W-1:0] base_addr_d, base_cnt_d, cur_addr_d, cur_cnt_d;
  logic [PW-1:0]    page_d;
  logic             changed_d;
  logic             any_wr;

  function automatic logic [REG_W-1:0] merge_byte(
    input logic [REG_W-1:0] old, input logic lo, input logic [BYTE_W-1:0] b);
    logic [REG_W-1:0] r;
    r = old;
    if (lo) r[BYTE_W-1:0]       = b;
    else    r[REG_W-1:BYTE_W]   = b;
    return r;
  endfunction

  always_comb begin
    any_wr      = wr_addr | wr_cnt | wr_page;
    base_addr_d = wr_addr ? merge_byte(base_addr, lo_sel, wdata) : base_addr;
    base_cnt_d  = wr_cnt  ? merge_byte(base_cnt,  lo_sel, wdata) : base_cnt;
    page_d      = wr_page ? PW'(wdata) : page;
    cur_addr_d  = ld_en ? ld_addr : cur_addr;
    cur_cnt_d   = ld_en ? ld_cnt  : cur_cnt;
    // a set in the same cycle wins over an acknowledge
    changed_d   = any_wr | (changed & ~ack);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_addr <= '0;
      base_cnt  <= '0;
      page      <= '0;
      cur_addr  <= '0;
      cur_cnt   <= '0;
      changed   <= 1'b0;
    end else begin
      if (wr_addr)      base_addr <= base_addr_d;
      if (wr_cnt)       base_cnt  <= base_cnt_d;
      if (wr_page)      page      <= page_d;
      if (ld_en) begin
        cur_addr <= cur_addr_d;
        cur_cnt  <= cur_cnt_d;
      end
      if (any_wr | ack) changed   <= changed_d;
    end
  end

endmodule

// File: rtl/dma_chan_regfile.sv
module dma_chan_regfile
  import dmareg_pkg::*;
#(
  parameter int NCH = 4,
  parameter int PW  = 8,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [7:0]           io_port,
  input  logic                 io_rd,
  input  logic                 io_wr,
  input  logic [7:0]           io_wdata,
  output logic [7:0]           io_rdata,
  input  logic                 ld_en,
  input  logic [CHW-1:0]       ld_chan,
  input  logic [REG_W-1:0]     ld_addr,
  input  logic [REG_W-1:0]     ld_cnt,
  input  logic [NCH-1:0]       chg_ack,
  output logic [NCH-1:0]       chg_flag,
  output logic [NCH*REG_W-1:0] base_addr_o,
  output logic [NCH*REG_W-1:0] base_cnt_o,
  output logic [NCH*PW-1:0]    page_o
);

  // reset synchroniser: asserts at once, releases on the clock
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  acc_kind_e      kind;
  logic [CHW-1:0] chan;

  dmareg_decode #(.NCH(NCH)) u_dec (
    .port (io_port),
    .kind (kind),
    .chan (chan)
  );

  // shared byte pointer
  logic ptr_q, ptr_d, ptr_en;
  always_comb begin
    ptr_en = (io_rd | io_wr) & ((kind == ACC_ADDR) | (kind == ACC_CNT));
    ptr_d  = ~ptr_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  ptr_q <= 1'b1;
    else if (ptr_en)  ptr_q <= ptr_d;
  end

  logic [REG_W-1:0] cur_addr [NCH];
  logic [REG_W-1:0] cur_cnt  [NCH];
  logic [PW-1:0]    page_r   [NCH];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic sel;
    assign sel = (chan == CHW'(i));
    dmareg_chan #(.PW(PW)) u_ch (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .wr_addr   (io_wr & sel & (kind == ACC_ADDR)),
      .wr_cnt    (io_wr & sel & (kind == ACC_CNT)),
      .wr_page   (io_wr & sel & (kind == ACC_PAGE)),
      .lo_sel    (ptr_q),
      .wdata     (io_wdata),
      .ld_en     (ld_en & (ld_chan == CHW'(i))),
      .ld_addr   (ld_addr),
      .ld_cnt    (ld_cnt),
      .ack       (chg_ack[i]),
      .base_addr (base_addr_o[i*REG_W +: REG_W]),
      .base_cnt  (base_cnt_o[i*REG_W +: REG_W]),
      .page      (page_r[i]),
      .cur_addr  (cur_addr[i]),
      .cur_cnt   (cur_cnt[i]),
      .changed   (chg_flag[i])
    );
    assign page_o[i*PW +: PW] = page_r[i];
  end

  // read mux
  logic [REG_W-1:0] rd_word;
  always_comb begin
    rd_word  = '0;
    io_rdata = 8'hFF;
    if (io_rd) begin
      case (kind)
        ACC_ADDR: begin
          rd_word  = cur_addr[chan];
          io_rdata = ptr_q ? rd_word[BYTE_W-1:0] : rd_word[REG_W-1:BYTE_W];
        end
        ACC_CNT: begin
          rd_word  = cur_cnt[chan] - REG_W'(1);
          io_rdata = ptr_q ? rd_word[BYTE_W-1:0] : rd_word[REG_W-1:BYTE_W];
        end
        ACC_PAGE: io_rdata = 8'(page_r[chan]);
        default:  io_rdata = 8'hFF;
      endcase
    end
  end

endmodule

// File: rtl/dmareg_chk.sv
module dmareg_chk #(
  parameter int NCH = 4,
  parameter int PW  = 8,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic              clk,
  input logic              rst_ni,
  input logic              ptr_q,
  input logic [7:0]        io_port,
  input logic              io_rd,
  input logic              io_wr,
  input logic [7:0]        io_rdata,
  input logic [NCH-1:0]    chg_ack,
  input logic [NCH-1:0]    chg_flag,
  input logic [NCH*16-1:0] base_addr_o,
  input logic [NCH*16-1:0] base_cnt_o,
  input logic [NCH*PW-1:0] page_o
);

  localparam logic [7:0] LIM = 8'(2 * NCH);

  logic           reg_acc, is_page, unmapped;
  logic [CHW-1:0] wch;
  assign reg_acc  = (io_rd | io_wr) & (io_port < LIM);
  assign is_page  = (io_port == 8'h81) | (io_port == 8'h82) |
                    (io_port == 8'h83) | (io_port == 8'h87);
  assign unmapped = (io_port >= LIM) & ~is_page;
  assign wch      = io_port[CHW:1];

  // R2
  ptr_toggle_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    reg_acc |=> (ptr_q != $past(ptr_q)));

  // R2
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !reg_acc |=> (ptr_q == $past(ptr_q)));

  // R8
  chg_set_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (io_wr && io_port < LIM) |=> chg_flag[$past(wch)]);

  // R9
  chg_clear_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    ((chg_ack != '0) && !io_wr) |=> ((chg_flag & $past(chg_ack)) == '0));

  // R10
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (io_rd && unmapped) |-> (io_rdata == 8'hFF));

  // R10
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (io_wr && !io_rd && unmapped) |=>
      ($stable(base_addr_o) && $stable(base_cnt_o) && $stable(page_o)));

endmodule

bind dma_chan_regfile dmareg_chk #(.NCH(NCH), .PW(PW)) u_chk (
  .clk         (clk),
  .rst_ni      (rst_sync_n),
  .ptr_q       (ptr_q),
  .io_port     (io_port),
  .io_rd       (io_rd),
  .io_wr       (io_wr),
  .io_rdata    (io_rdata),
  .chg_ack     (chg_ack),
  .chg_flag    (chg_flag),
  .base_addr_o (base_addr_o),
  .base_cnt_o  (base_cnt_o),
  .page_o      (page_o)
);

// File: tb/tb_dma_chan_regfile.sv
`timescale 1ns/1ps
module tb_dma_chan_regfile;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  io_port, io_wdata, io_rdata;
  logic        io_rd, io_wr, ld_en;
  logic [1:0]  ld_chan;
  logic [15:0] ld_addr, ld_cnt;
  logic [3:0]  chg_ack, chg_flag;
  logic [63:0] base_addr_o, base_cnt_o;
  logic [31:0] page_o;

  always #10 clk = ~clk; // 50 MHz

  dma_chan_regfile dut (
    .clk(clk), .rst_n(rst_n), .io_port(io_port), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .ld_en(ld_en), .ld_chan(ld_chan),
    .ld_addr(ld_addr), .ld_cnt(ld_cnt), .chg_ack(chg_ack), .chg_flag(chg_flag),
    .base_addr_o(base_addr_o), .base_cnt_o(base_cnt_o), .page_o(page_o)
  );

  // reference model
  logic [15:0] m_ba [4];
  logic [15:0] m_bc [4];
  logic [15:0] m_ca [4];
  logic [15:0] m_cc [4];
  logic [7:0]  m_pg [4];
  logic [3:0]  m_chg;
  logic        mptr;

  int n_chk = 0, n_fail = 0, mon_chk = 0, mon_fail = 0;
  bit done = 0;

  logic [7:0] exp_q [$];
  string      tag_q [$];

  function automatic int page_chan(input logic [7:0] p);
    case (p)
      8'h81: return 2;
      8'h82: return 3;
      8'h83: return 1;
      8'h87: return 0;
      default: return -1;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_state(input string tag);
    for (int c = 0; c < 4; c++) begin
      chk({tag, " base_addr"}, {16'h0, base_addr_o[c*16 +: 16]}, {16'h0, m_ba[c]});
      chk({tag, " base_cnt"},  {16'h0, base_cnt_o[c*16 +: 16]},  {16'h0, m_bc[c]});
      chk({tag, " page"},      {24'h0, page_o[c*8 +: 8]},        {24'h0, m_pg[c]});
    end
    chk({tag, " chg_flag"}, {28'h0, chg_flag}, {28'h0, m_chg});
  endtask

  task automatic model_write(input logic [7:0] p, input logic [7:0] d);
    int c;
    if (p < 8'd8) begin
      c = int'(p[2:1]);
      if (!p[0]) begin
        if (mptr) m_ba[c][7:0] = d; else m_ba[c][15:8] = d;
      end else begin
        if (mptr) m_bc[c][7:0] = d; else m_bc[c][15:8] = d;
      end
      m_chg[c] = 1'b1;
      mptr = ~mptr;
    end else if (page_chan(p) >= 0) begin
      c = page_chan(p);
      m_pg[c] = d;
      m_chg[c] = 1'b1;
    end
  endtask

  task automatic bus_wr(input logic [7:0] p, input logic [7:0] d, input logic [3:0] ack);
    @(posedge clk); #1;
    io_port = p; io_wdata = d; io_wr = 1'b1; chg_ack = ack;
    m_chg = m_chg & ~ack;
    model_write(p, d);
    @(posedge clk); #1;
    io_wr = 1'b0; chg_ack = 4'h0;
  endtask

  task automatic bus_rd(input logic [7:0] p, input string tag);
    logic [7:0]  e;
    logic [15:0] w;
    int c;
    e = 8'hFF;
    if (p < 8'd8) begin
      c = int'(p[2:1]);
      w = p[0] ? (m_cc[c] - 16'd1) : m_ca[c];
      e = mptr ? w[7:0] : w[15:8];
      mptr = ~mptr;
    end else if (page_chan(p) >= 0) begin
      e = m_pg[page_chan(p)];
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(posedge clk); #1;
    io_port = p; io_rd = 1'b1;
    @(posedge clk); #1;
    io_rd = 1'b0;
  endtask

  task automatic ack_only(input logic [3:0] m);
    @(posedge clk); #1;
    chg_ack = m; m_chg = m_chg & ~m;
    @(posedge clk); #1;
    chg_ack = 4'h0;
  endtask

  task automatic side_load(input logic [1:0] c, input logic [15:0] a, input logic [15:0] n);
    @(posedge clk); #1;
    ld_en = 1'b1; ld_chan = c; ld_addr = a; ld_cnt = n;
    m_ca[c] = a; m_cc[c] = n;
    @(posedge clk); #1;
    ld_en = 1'b0;
  endtask

  // monitor: compares read data mid-cycle
  always @(negedge clk) begin
    if (io_rd) begin
      mon_chk++;
      if (exp_q.size() == 0) begin
        mon_fail++;
        $display("FAIL read without expectation actual=%h expected=none", io_rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (io_rdata !== e) begin
          mon_fail++;
          $display("FAIL %s port=%h actual=%h expected=%h", t, io_port, io_rdata, e);
        end
      end
    end
  end

  initial begin
    rst_n = 1'b0; io_port = 8'h00; io_wdata = 8'h00; io_rd = 1'b0; io_wr = 1'b0;
    ld_en = 1'b0; ld_chan = 2'd0; ld_addr = 16'h0; ld_cnt = 16'h0; chg_ack = 4'h0;
    for (int c = 0; c < 4; c++) begin
      m_ba[c] = 0; m_bc[c] = 0; m_ca[c] = 0; m_cc[c] = 0; m_pg[c] = 0;
    end
    m_chg = 4'h0; mptr = 1'b1;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;

    check_state("R12 reset");
    bus_rd(8'h00, "R3 R5 reset low byte of address");
    bus_rd(8'h01, "R6 zero count high byte");
    bus_rd(8'h01, "R6 zero count low byte");
    bus_rd(8'h10, "R10 unmapped read");
    bus_rd(8'h00, "R2 R3 pointer held by unmapped read");

    bus_wr(8'h02, 8'h34, 4'h0);
    bus_wr(8'h02, 8'h12, 4'h0);
    check_state("R1 R4 R8 address write ch1");
    bus_wr(8'h02, 8'h99, 4'h0);
    check_state("R4 low byte rewrite");
    bus_wr(8'h02, 8'hAB, 4'h0);
    check_state("R4 high byte rewrite");

    bus_wr(8'h07, 8'h78, 4'h0);
    bus_wr(8'h07, 8'h56, 4'h0);
    check_state("R1 R4 count write ch3");

    bus_wr(8'h87, 8'h11, 4'h0);
    bus_wr(8'h83, 8'h22, 4'h0);
    bus_wr(8'h81, 8'h33, 4'h0);
    bus_wr(8'h82, 8'h44, 4'h0);
    check_state("R7 R8 page map");
    bus_rd(8'h81, "R7 page readback");
    bus_rd(8'h00, "R2 pointer held by page access");

    ack_only(4'hF);
    check_state("R9 acknowledge clears");
    bus_wr(8'h87, 8'h5A, 4'h0);
    check_state("R8 page write flags ch0");
    bus_wr(8'h00, 8'hC3, 4'h1);
    check_state("R9 write wins over acknowledge");
    ack_only(4'h1);
    check_state("R9 acknowledge after write");

    bus_wr(8'h84, 8'h55, 4'h0);
    bus_wr(8'h08, 8'h66, 4'h0);
    check_state("R10 unmapped writes ignored");

    side_load(2'd0, 16'hBEEF, 16'h0100);
    side_load(2'd2, 16'h1357, 16'h0001);
    bus_rd(8'h00, "R11 R5 ch0 address byte a");
    bus_rd(8'h00, "R11 R5 ch0 address byte b");
    bus_rd(8'h01, "R11 R6 ch0 count byte a");
    bus_rd(8'h01, "R11 R6 ch0 count byte b");
    bus_rd(8'h05, "R6 count one reads zero a");
    bus_rd(8'h05, "R6 count one reads zero b");
    bus_rd(8'h04, "R1 R5 ch2 address a");
    bus_rd(8'h04, "R1 R5 ch2 address b");
    check_state("R11 side load leaves base");

    repeat (3) @(posedge clk);
    #1;
    chk("R5 R6 all reads consumed", exp_q.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk + mon_chk, n_fail + mon_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==",
               n_chk + mon_chk + 1, n_fail + mon_fail + 1);
      $finish;
    end
  end

endmodule